// File: doc/BRIEF.md
# Word-to-Byte Dual-Clock FIFO

This block moves a stream of 32-bit words from a producer clock domain to a consumer that takes one byte at a time on its own, unrelated clock. A typical consumer is a digital-to-analog converter paced near 27 MHz. The producer side is a host-fed data path. Each accepted word is stored whole. The consumer then drains it as four bytes, starting at the least significant lane, so the byte sequence the host sent arrives unchanged.

The producer sees a write strobe, a data word and a full flag. The consumer sees a read strobe, a registered byte output and an empty flag. One reset input clears the FIFO. It is raised, for example, when both directions of the host stream are closed. The reset is brought separately into each clock domain before it acts there.

Pointer exchange between the domains uses Gray code and multi-flop synchronizers. Both flags are computed at word granularity. Either flag may stay asserted a little longer than strictly needed, but neither can let a write overrun stored data or let a read return an unwritten slot.

Top module: `w2n_fifo`

## Requirements
- R1: Each accepted word yields exactly four read bytes, in the order bits 7:0, 15:8, 23:16, then 31:24, so a word 32'h44332211 reads out as 8'h11, 8'h22, 8'h33, 8'h44.
- R2: Capacity is DEPTH_WORDS words (default 512, i.e. 2048 bytes). After 512 words are written with no reads and the flags have settled, full is 1. While full is 0, fewer than 512 words are held.
- R3: A write strobe while full is 1 is ignored: no data is stored, full stays 1, and the stored sequence is unaffected.
- R4: A read strobe while empty is 1 is ignored: rd_data holds its value, and no byte is consumed or skipped. While empty is 0, at least one unread byte is held.
- R5: The byte for a read accepted at a read-clock edge (rd_en high, empty low) appears on rd_data after that edge and holds until the next accepted read.
- R6: Once both sides have been idle for a few cycles of each clock, empty is 1 exactly when no unread byte is held, and full is 1 exactly when 512 words are held.
- R7: While rst is high and after it falls, the FIFO is empty: empty is 1 and full is 0. Data written before the reset is never read out.
- R8: Pointers cross domains in Gray code, changing by at most one bit per cycle of their own domain. A word written into an empty FIFO clears empty within SYNC_STAGES+2 read-clock cycles.
- R9: With both clocks running and reads and writes interleaved in any pattern, including long stretches where the writer is held off by full, every byte arrives once and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Producer clock |
| rd_clk | input | 1 | Consumer clock, unrelated to wr_clk |
| rst | input | 1 | Active-high reset for both domains, synchronized inside |
| wr_en | input | 1 | Write strobe, accepted when full is 0 |
| wr_data | input | 32 | Word to store, lane 0 in bits 7:0 |
| full | output | 1 | No room for another word (wr_clk domain) |
| rd_en | input | 1 | Read strobe, accepted when empty is 0 |
| rd_data | output | 8 | Registered byte from the oldest unread lane |
| empty | output | 1 | No unread byte (rd_clk domain) |

## Verification
The hardest situation to reach is full being asserted and released again and again while the reader is still draining. In that state the read pointer is in flight across the boundary, and the write side must hold off on a stale copy of it. The bench reaches this state by running the producer at full rate on the 125 MHz clock against a consumer near 27 MHz that reads on every cycle. The writer therefore outruns the reader and is throttled by full for most of the run. Every byte delivered is compared with a behavioural queue, and the flags are checked against the queue's occupancy on every cycle.

// File: rtl/w2n_fifo_pkg.sv
`timescale 1ns/1ps
package w2n_fifo_pkg;

    localparam int DEF_DATA_W      = 32;
    localparam int DEF_BYTE_W      = 8;
    localparam int DEF_DEPTH_WORDS = 512;
    localparam int DEF_SYNC_STAGES = 2;

    localparam int CODE_W = 32;

    function automatic logic [CODE_W-1:0] bin2gray(input logic [CODE_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [CODE_W-1:0] gray2bin(input logic [CODE_W-1:0] g);
        logic [CODE_W-1:0] r;
        r[CODE_W-1] = g[CODE_W-1];
        for (int i = CODE_W - 2; i >= 0; i--) begin
            r[i] = r[i+1] ^ g[i];
        end
        return r;
    endfunction

endpackage

// File: rtl/w2n_rst_sync.sv
`timescale 1ns/1ps
module w2n_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_in,
    output logic rst_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        chain <= {chain[STAGES-2:0], rst_in};
    end

    // Assertion takes effect at once, release follows the local clock.
    assign rst_out = rst_in | chain[STAGES-1];
endmodule

// File: rtl/w2n_sync_vec.sv
`timescale 1ns/1ps
module w2n_sync_vec #(
    parameter int W      = 10,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/w2n_wr_side.sv
`timescale 1ns/1ps
module w2n_wr_side #(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW:0]   rgray_s,
    output logic          fire,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray,
    output logic          full
);
    import w2n_fifo_pkg::*;

    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    logic [PW-1:0] wbin, wbin_nx, rbin_s;

    always_comb begin
        rbin_s  = PW'(gray2bin(CODE_W'(rgray_s)));
        wbin_nx = wbin + 1'b1;
        full    = (wbin[PW-1] != rbin_s[PW-1]) && (wbin[AW-1:0] == rbin_s[AW-1:0]);
        fire    = wr_en && !full;
        waddr   = wbin[AW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (fire) begin
            wbin  <= wbin_nx;
            wgray <= PW'(bin2gray(CODE_W'(wbin_nx)));
        end
    end

    AST_WR_IGNORED_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full) |=> $stable(wbin)); // R3

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (PW'(wbin - rbin_s) <= PW'(DEPTH))); // R2

    AST_WGRAY_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        ($countones(wgray ^ $past(wgray)) <= 1)); // R8
endmodule

// File: rtl/w2n_rd_side.sv
`timescale 1ns/1ps
module w2n_rd_side #(
    parameter int AW = 9,
    parameter int LB = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic [AW:0]   wgray_s,
    output logic          fire,
    output logic [AW-1:0] raddr,
    output logic [LB-1:0] lane,
    output logic [AW:0]   rgray,
    output logic          empty
);
    import w2n_fifo_pkg::*;

    localparam int PW    = AW + 1;
    localparam int RPW   = PW + LB;
    localparam int DEPTH = 1 << AW;

    logic [RPW-1:0] rbin, rbin_nx;
    logic [PW-1:0]  rword, wbin_s;

    always_comb begin
        wbin_s  = PW'(gray2bin(CODE_W'(wgray_s)));
        rword   = rbin[RPW-1:LB];
        lane    = rbin[LB-1:0];
        raddr   = rword[AW-1:0];
        empty   = (rword == wbin_s);
        fire    = rd_en && !empty;
        rbin_nx = rbin + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rbin  <= '0;
            rgray <= '0;
        end else if (fire) begin
            rbin  <= rbin_nx;
            rgray <= PW'(bin2gray(CODE_W'(rbin_nx[RPW-1:LB])));
        end
    end

    AST_RD_IGNORED_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (rd_en && empty) |=> $stable(rbin)); // R4

    AST_LANE_STEP: assert property (@(posedge clk) disable iff (rst)
        fire |=> (lane == LB'($past(lane) + 1'b1))); // R1

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (PW'(wbin_s - rword) <= PW'(DEPTH))); // R4

    AST_RGRAY_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        ($countones(rgray ^ $past(rgray)) <= 1)); // R8
endmodule

// File: rtl/w2n_store.sv
`timescale 1ns/1ps
module w2n_store #(
    parameter int DW = 32,
    parameter int BW = 8,
    parameter int AW = 9
) (
    input  logic                      wclk,
    input  logic                      we,
    input  logic [AW-1:0]             waddr,
    input  logic [DW-1:0]             wdata,
    input  logic                      rclk,
    input  logic                      rrst,
    input  logic                      re,
    input  logic [AW-1:0]             raddr,
    input  logic [$clog2(DW/BW)-1:0]  lane,
    output logic [BW-1:0]             rdata
);
    localparam int LANES = DW / BW;
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] head_word;
    logic [BW-1:0] lane_v [LANES];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign head_word = mem[raddr];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_v[g] = head_word[g*BW +: BW];
    end

    always_ff @(posedge rclk) begin
        if (rrst)    rdata <= '0;
        else if (re) rdata <= lane_v[lane];
    end

    AST_RD_HOLD: assert property (@(posedge rclk) disable iff (rrst)
        !$past(re) |-> $stable(rdata)); // R5
endmodule

// File: rtl/w2n_fifo.sv
`timescale 1ns/1ps
module w2n_fifo #(
    parameter int DATA_W      = w2n_fifo_pkg::DEF_DATA_W,
    parameter int BYTE_W      = w2n_fifo_pkg::DEF_BYTE_W,
    parameter int DEPTH_WORDS = w2n_fifo_pkg::DEF_DEPTH_WORDS,
    parameter int SYNC_STAGES = w2n_fifo_pkg::DEF_SYNC_STAGES
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              full,
    input  logic              rd_en,
    output logic [BYTE_W-1:0] rd_data,
    output logic              empty
);
    localparam int LANES = DATA_W / BYTE_W;
    localparam int LB    = $clog2(LANES);
    localparam int AW    = $clog2(DEPTH_WORDS);
    localparam int PW    = AW + 1;

    logic          wrst, rrst;
    logic          wr_fire, rd_fire;
    logic [AW-1:0] waddr, raddr;
    logic [LB-1:0] lane;
    logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;

    w2n_rst_sync #(.STAGES(SYNC_STAGES)) u_wrst (
        .clk(wr_clk), .rst_in(rst), .rst_out(wrst));

    w2n_rst_sync #(.STAGES(SYNC_STAGES)) u_rrst (
        .clk(rd_clk), .rst_in(rst), .rst_out(rrst));

    w2n_sync_vec #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
        .clk(wr_clk), .rst(wrst), .d(rgray), .q(rgray_s));

    w2n_sync_vec #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
        .clk(rd_clk), .rst(rrst), .d(wgray), .q(wgray_s));

    w2n_wr_side #(.AW(AW)) u_wr (
        .clk(wr_clk), .rst(wrst), .wr_en(wr_en), .rgray_s(rgray_s),
        .fire(wr_fire), .waddr(waddr), .wgray(wgray), .full(full));

    w2n_rd_side #(.AW(AW), .LB(LB)) u_rd (
        .clk(rd_clk), .rst(rrst), .rd_en(rd_en), .wgray_s(wgray_s),
        .fire(rd_fire), .raddr(raddr), .lane(lane), .rgray(rgray), .empty(empty));

    w2n_store #(.DW(DATA_W), .BW(BYTE_W), .AW(AW)) u_mem (
        .wclk(wr_clk), .we(wr_fire), .waddr(waddr), .wdata(wr_data),
        .rclk(rd_clk), .rrst(rrst), .re(rd_fire), .raddr(raddr), .lane(lane),
        .rdata(rd_data));

    AST_RESET_EMPTY: assert property (@(posedge rd_clk)
        $past(rrst) |-> empty); // R7

    AST_RESET_NOT_FULL: assert property (@(posedge wr_clk)
        $past(wrst) |-> !full); // R7
endmodule

// File: tb/w2n_fifo_tb_top.sv
`timescale 1ns/1ps
module w2n_fifo_tb_top;
    localparam int DEPTH = 512;

    logic        wr_clk = 0, rd_clk = 0, rst = 1;
    logic        wr_en = 0, rd_en = 0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_data;
    logic        full, empty;

    always #4    wr_clk = ~wr_clk;
    always #18.5 rd_clk = ~rd_clk;

    w2n_fifo dut_i (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst),
        .wr_en(wr_en), .wr_data(wr_data), .full(full),
        .rd_en(rd_en), .rd_data(rd_data), .empty(empty));

    int checks = 0, errors = 0;
    logic [7:0] q[$];
    int words_in = 0, bytes_out = 0;
    logic [7:0] pend;
    bit pend_v = 0;
    bit done_flag = 0;

    function automatic int occ_words();
        return words_in - bytes_out / 4;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h @%0t", req, act, exp, $time);
        end
    endtask

    task automatic push_word(input logic [31:0] w);
        for (int l = 0; l < 4; l++) q.push_back(w[l*8 +: 8]);
        words_in++;
    endtask

    task automatic do_reset();
        @(negedge rd_clk);
        rst = 1; wr_en = 0; rd_en = 0;
        repeat (4) @(negedge rd_clk);
        chk(empty == 1, "R7 empty during reset", empty, 1);
        rst = 0;
        q.delete(); words_in = 0; bytes_out = 0; pend_v = 0;
        repeat (6) @(negedge rd_clk);
        chk(empty == 1, "R7 empty after reset", empty, 1);
        @(negedge wr_clk);
        chk(full == 0, "R7 full after reset", full, 0);
    endtask

    task automatic wr_words(input int n, input int gap);
        int done = 0;
        while (done < n) begin
            @(negedge wr_clk);
            if (!full) chk(occ_words() < DEPTH, "R2 not full implies room", occ_words(), DEPTH - 1);
            if (!full && (gap == 0 || $urandom_range(gap) == 0)) begin
                wr_en = 1;
                wr_data = $urandom;
                push_word(wr_data);
                done++;
            end else begin
                wr_en = 0;
            end
        end
        @(negedge wr_clk);
        wr_en = 0;
    endtask

    task automatic rd_step(input bit want);
        if (pend_v) chk(rd_data == pend, "R1/R5/R9 byte data", rd_data, pend);
        pend_v = 0;
        if (!empty) chk(q.size() > 0, "R4 not empty implies data", q.size(), 1);
        if (!empty && want && q.size() > 0) begin
            rd_en = 1;
            pend = q.pop_front();
            pend_v = 1;
            bytes_out++;
        end else begin
            rd_en = 0;
        end
    endtask

    task automatic rd_bytes(input int n, input int gap);
        int start = bytes_out;
        while (bytes_out - start < n) begin
            @(negedge rd_clk);
            rd_step(gap == 0 || $urandom_range(gap) == 0);
        end
        @(negedge rd_clk);
        rd_step(0);
    endtask

    task automatic settle();
        repeat (12) @(negedge rd_clk);
        chk(empty == (q.size() == 0), "R6 settled empty", empty, q.size() == 0);
        @(negedge wr_clk);
        chk(full == (occ_words() == DEPTH), "R6 settled full", full, occ_words() == DEPTH);
    endtask

    initial begin
        #1_000_000;
        if (!done_flag) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge rd_clk);
        do_reset();

        // R1: byte order of a known word
        @(negedge wr_clk);
        wr_en = 1; wr_data = 32'h44332211; push_word(wr_data);
        @(negedge wr_clk);
        wr_en = 0;
        // R8: visibility within SYNC_STAGES+2 read cycles
        repeat (4) @(negedge rd_clk);
        chk(empty == 0, "R8 write visible to reader", empty, 0);
        for (int k = 0; k < 4; k++) begin
            logic [7:0] e;
            e = q[0];
            rd_step(1);
            @(negedge rd_clk);
            chk(rd_data == e && e == 8'(8'h11 * (k + 1)), "R1 lane order", rd_data, 8'(8'h11 * (k + 1)));
            pend_v = 0;
            rd_en = 0;
        end
        settle();

        // R4: reads while empty are ignored
        for (int k = 0; k < 5; k++) begin
            @(negedge rd_clk);
            rd_en = 1;
            chk(empty == 1, "R4 empty held", empty, 1);
            chk(rd_data == 8'h44, "R4 rd_data held", rd_data, 8'h44);
        end
        @(negedge rd_clk);
        rd_en = 0;
        chk(rd_data == 8'h44, "R4 rd_data held after strobe", rd_data, 8'h44);
        wr_words(1, 0);
        rd_bytes(4, 0);
        settle();

        // R2 and R3: fill, then push against full
        wr_words(DEPTH, 0);
        settle();
        @(negedge wr_clk);
        chk(full == 1, "R2 full at capacity", full, 1);
        for (int k = 0; k < 6; k++) begin
            @(negedge wr_clk);
            wr_en = 1; wr_data = 32'hDEADBEEF;
            chk(full == 1, "R3 full held under write", full, 1);
        end
        @(negedge wr_clk);
        wr_en = 0;
        rd_bytes(DEPTH * 4, 0);
        settle();

        // R9: irregular traffic on both sides
        fork
            wr_words(300, 3);
            rd_bytes(1200, 1);
        join
        settle();

        // R9: writer throttled by full while reader drains
        fork
            wr_words(700, 0);
            rd_bytes(2800, 0);
        join
        settle();

        // R7: reset with data inside
        wr_words(20, 0);
        settle();
        do_reset();
        wr_words(2, 0);
        rd_bytes(8, 0);
        settle();

        done_flag = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule